// File: doc/BRIEF.md
# Per-Core Two-Stage Tick Timer

This block is the local event timer of one processor core. Its first stage is a prescaler: a tick counter, loaded from a tick reload register, counts timer clocks down and emits one tick each time it runs out. Its second stage is an interrupt counter, loaded from an interval register, that steps down once per tick. When that counter runs out, the block latches a pending flag and, if the interrupt is enabled, drives its interrupt line. The event period is therefore the tick reload value times the interval count, in timer clocks.

Software reaches the block through a plain single-cycle register port. Writes take effect on the clock edge on which `reg_wr` is high, and reads are combinational on `reg_addr`. The port has no stream traffic, so there is no valid/ready handshake and no back-pressure. A write to the interval register changes only the stored reload value, unless bit 31 of the written word is set, in which case the running interrupt counter is overwritten as well. In periodic mode both counters reload on every expiry and the timer fires on its own until software clears its start bits. In one-shot mode the block stops itself after the first event.

Top module: `core_tick_timer`

## Requirements
- R1: While the tick start bit is set, the tick counter (read at address 5) decrements once per clock. In any cycle in which it holds 1 or 0, it produces a tick and reloads from the tick reload register (address 0, full 32 bits). A reload value of 1 therefore gives one tick per clock, and reload value T with interval count N gives an event T*N clocks after the start write.
- R2: While the interval start bit is set, the interrupt counter (read at address 6) decrements once per tick. A tick that finds it at 1 or 0 is an expiry, and the expiry reloads the counter from the interval register.
- R3: A write to address 1 stores bits 30:0 in the interval register, so the longest count is 0x7FFFFFFF. Only when bit 31 of that write is 1 is the value also copied into the interrupt counter on the same edge. With bit 31 at 0, the running count is left unchanged.
- R4: An expiry sets the pending flag (address 4, bit 0). The interrupt output equals the pending flag AND the enable bit (address 3, bit 0), so a disabled interrupt still records the pending flag.
- R5: The control register at address 2 holds tick start in bit 0, interval start in bit 1 and periodic mode in bit 2. With periodic mode set, the block keeps firing every period. With it clear, an expiry clears both start bits, unless a control write lands on the same edge, in which case the write wins.
- R6: Clearing a start bit freezes its counter. Writing a start bit from 0 to 1 reloads that counter from its reload register, and writing a 1 over a 1 does not.
- R7: Writing 1 to bit 0 of address 4 clears the pending flag, and writing 0 there has no effect. An expiry on the same edge as a clear leaves the flag set.
- R8: After reset every register and counter reads 0 and the interrupt output is low.
- R9: Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one edge per write |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data at reg_addr |
| irq | output | 1 | Interrupt, pending flag gated by enable |

## Verification
The in-RTL assertions check, on every cycle, the following rules:
- the tick counter reloads after each tick;
- a stopped counter holds its value;
- a flagged interval write lands in the running counter;
- an expiry sets the pending flag;
- a one-shot expiry clears the start bits;
- a write-1 clear empties the pending flag.

Some behaviour spans many cycles and only the bench scenarios can show it:
- the event period equals the tick reload value times the interval count;
- periodic refiring goes on after the flag is cleared;
- an unflagged interval write leaves the running count alone;
- a restart reloads from the buffers.

The cycle model in the bench also compares every readable register and the interrupt pin on every clock.

// File: rtl/ctt_pkg.sv
package ctt_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int UPD_BIT = DATA_W - 1;

  localparam logic [ADDR_W-1:0] A_TICK_RELOAD = 3'd0;
  localparam logic [ADDR_W-1:0] A_INTV_RELOAD = 3'd1;
  localparam logic [ADDR_W-1:0] A_CONTROL     = 3'd2;
  localparam logic [ADDR_W-1:0] A_IRQ_ENABLE  = 3'd3;
  localparam logic [ADDR_W-1:0] A_IRQ_PENDING = 3'd4;
  localparam logic [ADDR_W-1:0] A_TICK_COUNT  = 3'd5;
  localparam logic [ADDR_W-1:0] A_INTV_COUNT  = 3'd6;

  localparam int B_TICK_RUN = 0;
  localparam int B_INTV_RUN = 1;
  localparam int B_PERIODIC = 2;

  typedef struct packed {
    logic periodic;
    logic intv_run;
    logic tick_run;
  } ctrl_t;
endpackage

// File: rtl/ctt_tick_stage.sv
module ctt_tick_stage #(
  parameter int TICK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              load,
  input  logic [TICK_W-1:0] reload_val,
  output logic              tick,
  output logic [TICK_W-1:0] count
);
  localparam logic [TICK_W-1:0] ONE = TICK_W'(1);

  assign tick = run && (count <= ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (load)   count <= reload_val;
    else if (tick)   count <= reload_val;
    else if (run)    count <= count - ONE;
  end

  a_r1_tick_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> (count == $past(reload_val)));

  a_r6_tick_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(count));
endmodule

// File: rtl/ctt_intv_stage.sv
module ctt_intv_stage #(
  parameter int CNT_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             step,
  input  logic             load,
  input  logic             upd,
  input  logic [CNT_W-1:0] upd_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic             fire,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign fire = run && step && (count <= ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            count <= '0;
    else if (upd)          count <= upd_val;
    else if (load)         count <= reload_val;
    else if (fire)         count <= reload_val;
    else if (run && step)  count <= count - ONE;
  end

  a_r3_update_copies: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (count == $past(upd_val)));

  a_r6_intv_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !upd && !load) |=> $stable(count));
endmodule

// File: rtl/ctt_regs.sv
module ctt_regs
  import ctt_pkg::*;
#(
  parameter int TICK_W = 32,
  parameter int CNT_W  = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              fire,
  input  logic [TICK_W-1:0] tick_cnt,
  input  logic [CNT_W-1:0]  intv_cnt,
  output logic [DATA_W-1:0] rdata,
  output logic [TICK_W-1:0] tick_reload,
  output logic [CNT_W-1:0]  intv_reload,
  output ctrl_t             ctrl,
  output logic              tick_load,
  output logic              intv_load,
  output logic              upd_load,
  output logic [CNT_W-1:0]  upd_val,
  output logic              irq
);
  logic irq_en;
  logic pending;
  logic wr_ctrl;
  logic wr_pend;

  assign wr_ctrl   = wr && (addr == A_CONTROL);
  assign wr_pend   = wr && (addr == A_IRQ_PENDING);
  assign tick_load = wr_ctrl && wdata[B_TICK_RUN] && !ctrl.tick_run;
  assign intv_load = wr_ctrl && wdata[B_INTV_RUN] && !ctrl.intv_run;
  assign upd_load  = wr && (addr == A_INTV_RELOAD) && wdata[UPD_BIT];
  assign upd_val   = wdata[CNT_W-1:0];
  assign irq       = pending && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_reload <= '0;
      intv_reload <= '0;
      irq_en      <= 1'b0;
    end else if (wr) begin
      if (addr == A_TICK_RELOAD) tick_reload <= wdata[TICK_W-1:0];
      if (addr == A_INTV_RELOAD) intv_reload <= wdata[CNT_W-1:0];
      if (addr == A_IRQ_ENABLE)  irq_en      <= wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (wr_ctrl) begin
      ctrl.tick_run <= wdata[B_TICK_RUN];
      ctrl.intv_run <= wdata[B_INTV_RUN];
      ctrl.periodic <= wdata[B_PERIODIC];
    end else if (fire && !ctrl.periodic) begin
      ctrl.tick_run <= 1'b0;
      ctrl.intv_run <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   pending <= 1'b0;
    else if (fire)                pending <= 1'b1;
    else if (wr_pend && wdata[0]) pending <= 1'b0;
  end

  always_comb begin
    case (addr)
      A_TICK_RELOAD: rdata = DATA_W'(tick_reload);
      A_INTV_RELOAD: rdata = DATA_W'(intv_reload);
      A_CONTROL:     rdata = DATA_W'(ctrl);
      A_IRQ_ENABLE:  rdata = DATA_W'(irq_en);
      A_IRQ_PENDING: rdata = DATA_W'(pending);
      A_TICK_COUNT:  rdata = DATA_W'(tick_cnt);
      A_INTV_COUNT:  rdata = DATA_W'(intv_cnt);
      default:       rdata = '0;
    endcase
  end

  a_r4_fire_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> pending);

  a_r5_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !ctrl.periodic && !wr_ctrl) |=> (!ctrl.tick_run && !ctrl.intv_run));

  a_r7_write_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && wdata[0] && !fire) |=> !pending);
endmodule

// File: rtl/core_tick_timer.sv
module core_tick_timer
  import ctt_pkg::*;
#(
  parameter int TICK_W = 32,
  parameter int CNT_W  = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [TICK_W-1:0] tick_reload;
  logic [TICK_W-1:0] tick_cnt;
  logic [CNT_W-1:0]  intv_reload;
  logic [CNT_W-1:0]  intv_cnt;
  logic [CNT_W-1:0]  upd_val;
  ctrl_t             ctrl;
  logic              tick_load;
  logic              intv_load;
  logic              upd_load;
  logic              tick;
  logic              fire;

  ctt_regs #(.TICK_W(TICK_W), .CNT_W(CNT_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (reg_wr),
    .addr        (reg_addr),
    .wdata       (reg_wdata),
    .fire        (fire),
    .tick_cnt    (tick_cnt),
    .intv_cnt    (intv_cnt),
    .rdata       (reg_rdata),
    .tick_reload (tick_reload),
    .intv_reload (intv_reload),
    .ctrl        (ctrl),
    .tick_load   (tick_load),
    .intv_load   (intv_load),
    .upd_load    (upd_load),
    .upd_val     (upd_val),
    .irq         (irq)
  );

  ctt_tick_stage #(.TICK_W(TICK_W)) u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (ctrl.tick_run),
    .load       (tick_load),
    .reload_val (tick_reload),
    .tick       (tick),
    .count      (tick_cnt)
  );

  ctt_intv_stage #(.CNT_W(CNT_W)) u_intv (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (ctrl.intv_run),
    .step       (tick),
    .load       (intv_load),
    .upd        (upd_load),
    .upd_val    (upd_val),
    .reload_val (intv_reload),
    .fire       (fire),
    .count      (intv_cnt)
  );
endmodule

// File: tb/test_core_tick_timer.sv
module test_core_tick_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;

  core_tick_timer i_core_tick_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model, one update per clock edge
  logic [31:0] m_tbuf, m_tcnt;
  logic [30:0] m_ibuf, m_icnt;
  bit m_trun, m_irun, m_per, m_en, m_pend;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tbuf = 0; m_tcnt = 0; m_ibuf = 0; m_icnt = 0;
      m_trun = 0; m_irun = 0; m_per = 0; m_en = 0; m_pend = 0;
    end else begin
      bit tk, fr;
      logic [31:0] n_tcnt;
      logic [30:0] n_icnt;
      tk = m_trun && (m_tcnt <= 1);
      fr = m_irun && tk && (m_icnt <= 1);
      n_tcnt = m_tcnt;
      if (reg_wr && reg_addr == 2 && reg_wdata[0] && !m_trun) n_tcnt = m_tbuf;
      else if (tk) n_tcnt = m_tbuf;
      else if (m_trun) n_tcnt = m_tcnt - 1;
      n_icnt = m_icnt;
      if (reg_wr && reg_addr == 1 && reg_wdata[31]) n_icnt = reg_wdata[30:0];
      else if (reg_wr && reg_addr == 2 && reg_wdata[1] && !m_irun) n_icnt = m_ibuf;
      else if (fr) n_icnt = m_ibuf;
      else if (m_irun && tk) n_icnt = m_icnt - 1;
      m_tcnt = n_tcnt;
      m_icnt = n_icnt;
      if (reg_wr && reg_addr == 2) begin
        m_trun = reg_wdata[0]; m_irun = reg_wdata[1]; m_per = reg_wdata[2];
      end else if (fr && !m_per) begin
        m_trun = 0; m_irun = 0;
      end
      if (fr) m_pend = 1;
      else if (reg_wr && reg_addr == 4 && reg_wdata[0]) m_pend = 0;
      if (reg_wr && reg_addr == 0) m_tbuf = reg_wdata;
      if (reg_wr && reg_addr == 1) m_ibuf = reg_wdata[30:0];
      if (reg_wr && reg_addr == 3) m_en = reg_wdata[0];
    end
  end

  function automatic logic [31:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return m_tbuf;
      3'd1: return {1'b0, m_ibuf};
      3'd2: return {29'd0, m_per, m_irun, m_trun};
      3'd3: return {31'd0, m_en};
      3'd4: return {31'd0, m_pend};
      3'd5: return m_tcnt;
      3'd6: return {1'b0, m_icnt};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string addr_tag(input logic [2:0] a);
    case (a)
      3'd0, 3'd1: return "R3";
      3'd2: return "R5";
      3'd3, 3'd4: return "R4";
      3'd5: return "R1";
      3'd6: return "R2";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 irq pin", {31'd0, irq}, {31'd0, m_pend && m_en});
      chk(addr_tag(reg_addr), reg_rdata, model_read(reg_addr));
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_wdata = 32'd0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq && n < 2000) begin
      @(posedge clk); #1; n++;
    end
  endtask

  task automatic idle(input int k);
    repeat (k) begin @(posedge clk); #1; end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d, hold;
    int n;
    repeat (3) @(posedge clk); #1; rst_n = 1'b1;

    // R8 reset values
    rd_reg(3'd2, d); chk("R8 control", d, 0);
    rd_reg(3'd4, d); chk("R8 pending", d, 0);
    rd_reg(3'd5, d); chk("R8 tick count", d, 0);
    chk("R8 irq", {31'd0, irq}, 0);

    // R3 update flag
    wr_reg(3'd1, 32'h8000_0005);
    rd_reg(3'd6, d); chk("R3 flagged write", d, 5);
    wr_reg(3'd1, 32'd9);
    rd_reg(3'd6, d); chk("R3 unflagged write keeps count", d, 5);
    rd_reg(3'd1, d); chk("R3 buffer", d, 9);

    // R1/R2 tick reload 1, interval 9, periodic
    wr_reg(3'd0, 32'd1);
    wr_reg(3'd3, 32'd1);
    wr_reg(3'd2, 32'd7);
    wait_irq(n); chk("R2 first event edges", n, 9);
    rd_reg(3'd4, d); chk("R4 pending set", d, 1);
    rd_reg(3'd2, d); chk("R5 periodic keeps running", d, 7);

    // R7 clear behaviour, R5 refire
    wr_reg(3'd4, 32'd0);
    rd_reg(3'd4, d); chk("R7 write zero no effect", d, 1);
    wr_reg(3'd4, 32'd1);
    chk("R7 cleared irq", {31'd0, irq}, 0);
    wait_irq(n); chk("R5 periodic refire edges", n, 7);

    // R4 disabled interrupt still records pending
    wr_reg(3'd3, 32'd0);
    wr_reg(3'd4, 32'd1);
    idle(10);
    rd_reg(3'd4, d); chk("R4 pending while disabled", d, 1);
    chk("R4 irq masked", {31'd0, irq}, 0);

    // R6 stopped counters freeze
    wr_reg(3'd2, 32'd0);
    wr_reg(3'd4, 32'd1);
    wr_reg(3'd3, 32'd1);
    rd_reg(3'd6, hold);
    idle(5);
    rd_reg(3'd6, d); chk("R6 interval counter frozen", d, hold);

    // R1 tick reload 3, interval 4, one-shot
    wr_reg(3'd0, 32'd3);
    wr_reg(3'd1, 32'h8000_0004);
    wr_reg(3'd2, 32'd3);
    wait_irq(n); chk("R1 period is reload times count", n, 12);
    rd_reg(3'd2, d); chk("R5 one-shot clears start bits", d, 0);
    rd_reg(3'd6, d); chk("R2 reload after expiry", d, 4);

    // R6 interval counter held while only ticks run, reload on restart
    wr_reg(3'd4, 32'd1);
    wr_reg(3'd2, 32'd1);
    wr_reg(3'd1, 32'd7);
    idle(6);
    rd_reg(3'd6, d); chk("R3 unflagged write while stopped", d, 4);
    wr_reg(3'd2, 32'd3);
    rd_reg(3'd6, d); chk("R6 restart reloads from buffer", d, 7);
    idle(3);
    rd_reg(3'd7, d); chk("R9 unused address", d, 0);
    wr_reg(3'd2, 32'd0);
    idle(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule